// File: doc/BRIEF.md
# Serial NVM Word Fetch Engine

This block lets a host pull 16-bit words out of a serial non-volatile memory through one 32-bit control/status word. The host writes the word address together with a start bit. The engine then requests that word from a simple back-end port and waits for the acknowledge. When the word arrives, the engine places it in the upper half of the same control/status word and raises a done flag. The host polls for that flag.

A sequencer sits beside the register. It accepts a burst request made of a starting offset and a word count, and checks the request against the device size presented on a configuration input. A request that fits is run as back-to-back single-word reads at consecutive addresses. Each read is polled for done before the next one starts, and each word is delivered on a streaming output. A read that never completes is abandoned after a bounded number of polls and reported as a timeout. The serial wire protocol is not part of the block. The back-end is a request/acknowledge port with any latency.

Top module: `nvm_word_reader`

## Requirements
- R1: Writing the register with bit 0 (start) set begins a read of the word whose address is in bits 15:2. The engine raises `be_req` with `be_addr` equal to that address. The cycle after `be_ack`, bits 31:16 hold `be_rdata`, bit 1 (done) is 1, and bit 0 (busy) is 0.
- R2: An accepted start clears done and the data field at the same edge and sets busy. Done then holds, along with the data field, until the next accepted start. Done and busy are never both 1.
- R3: A start written while busy is 1 is ignored. A write whose bit 0 is 0 changes nothing.
- R4: `be_req` stays high with a stable `be_addr` until `be_ack`. With an acknowledge L cycles after the request is seen, done appears L+1 cycles after the start write.
- R5: After reset the register reads as all zeros, `be_req` is low and the sequencer is idle.
- R6: A burst request delivers `count` words in address order, from `offset` to `offset+count-1`. Each word appears on `seq_word_valid` with its index counted from 0. `seq_done` pulses with the last word.
- R7: A burst is rejected if offset >= `dev_words`, if count is 0, or if count > `dev_words`-offset. Rejection pulses `seq_err_bounds` together with `seq_done`, delivers no word and issues no back-end request.
- R8: If done is not seen within POLL_LIMIT polls, `seq_err_timeout` and `seq_done` pulse exactly POLL_LIMIT+2 cycles after the burst start. The pending read is cancelled, which drops `be_req` and clears busy.
- R9: Host writes are ignored while the sequencer is busy or is being started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the control/status word |
| host_wdata | input | 32 | Host write data (bit 0 start, bits 15:2 address) |
| host_rdata | output | 32 | Control/status word: data, address, done, busy |
| seq_start | input | 1 | Start a burst read |
| seq_offset | input | 14 | First word address of the burst |
| seq_count | input | 15 | Number of words in the burst |
| dev_words | input | 15 | Device size in words |
| seq_busy | output | 1 | Burst in progress |
| seq_word_valid | output | 1 | A burst word is presented |
| seq_word_data | output | 16 | Burst word value |
| seq_word_idx | output | 15 | Index of the word within the burst |
| seq_done | output | 1 | Burst finished (success or error) |
| seq_err_bounds | output | 1 | Burst rejected by the bounds check |
| seq_err_timeout | output | 1 | Burst abandoned on a poll timeout |
| be_req | output | 1 | Back-end word request |
| be_addr | output | 14 | Back-end word address |
| be_ack | input | 1 | Back-end completion strobe |
| be_rdata | input | 16 | Back-end word value, valid with be_ack |

## Verification
The bench sweeps every offset and count from 0 to 9 against two small device sizes, so every edge of the bounds rule is crossed. A design with an off-by-one in the remaining-words comparison would reject a burst ending on the last word, or accept one that runs past it. Direct reads cover the address extremes and back-end latencies from 1 to 20 cycles, and each completion is timed to the cycle. A start that leaks through while busy would show up as a replaced address field. A host write that gets past the sequencer would corrupt the burst or leave the wrong address behind. A silent back-end checks that the timeout fires on the exact poll count and that the pending request is withdrawn.

// File: rtl/nvm_rd_pkg.sv
package nvm_rd_pkg;
  localparam int REG_W     = 32;
  localparam int START_BIT = 0;
  localparam int DONE_BIT  = 1;
  localparam int ADDR_LSB  = 2;
  localparam int ADDR_W    = 14;
  localparam int DATA_LSB  = ADDR_LSB + ADDR_W;
  localparam int DATA_W    = REG_W - DATA_LSB;
  localparam int CNT_W     = ADDR_W + 1;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
  import nvm_rd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic [AW-1:0] wr_addr,
  input  logic          cancel,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          be_req,
  output logic [AW-1:0] be_addr,
  input  logic          be_ack,
  input  logic [DW-1:0] be_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy && be_ack) begin
      busy   <= 1'b0;
      done   <= 1'b1;
      data_q <= be_rdata;
    end else if (busy && cancel) begin
      busy <= 1'b0;
    end else if (wr_start && !busy) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      data_q <= '0;
      addr_q <= wr_addr;
    end
  end

  assign be_req  = busy;
  assign be_addr = addr_q;
endmodule

// File: rtl/nvm_bounds.sv
module nvm_bounds #(
  parameter int AW = 14,
  parameter int CW = AW + 1
) (
  input  logic [AW-1:0] offset,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] size,
  output logic          reject
);
  logic [CW-1:0] off_ext;
  logic [CW-1:0] remain;
  logic          off_bad;

  always_comb begin
    off_ext = CW'(offset);
    off_bad = (off_ext >= size);
    remain  = off_bad ? '0 : (size - off_ext);
    reject  = off_bad || (count == '0) || (count > remain);
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_rd_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int CW         = CNT_W,
  parameter int DW         = DATA_W,
  parameter int POLL_LIMIT = 100000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] offset,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] size,
  output logic          busy,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] word_idx,
  output logic          done,
  output logic          err_bounds,
  output logic          err_timeout,
  output logic          iss_start,
  output logic [AW-1:0] iss_addr,
  output logic          cancel,
  input  logic          reg_done,
  input  logic [DW-1:0] reg_data
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  sq_state_t     st;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] idx;
  logic [CW-1:0] last_idx;
  logic [PW-1:0] poll;
  logic          reject;
  logic          poll_out;

  nvm_bounds #(.AW(AW), .CW(CW)) u_bounds (
    .offset (offset),
    .count  (count),
    .size   (size),
    .reject (reject)
  );

  assign poll_out = (st == SQ_WAIT) && !reg_done && (poll == POLL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      cur_addr    <= '0;
      idx         <= '0;
      last_idx    <= '0;
      poll        <= '0;
      word_valid  <= 1'b0;
      word_data   <= '0;
      word_idx    <= '0;
      done        <= 1'b0;
      err_bounds  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      word_valid  <= 1'b0;
      done        <= 1'b0;
      err_bounds  <= 1'b0;
      err_timeout <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            if (reject) begin
              err_bounds <= 1'b1;
              done       <= 1'b1;
            end else begin
              cur_addr <= offset;
              idx      <= '0;
              last_idx <= count - CW'(1);
              st       <= SQ_ISSUE;
            end
          end
        end
        SQ_ISSUE: begin
          poll <= '0;
          st   <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (reg_done) begin
            word_valid <= 1'b1;
            word_data  <= reg_data;
            word_idx   <= idx;
            if (idx == last_idx) begin
              done <= 1'b1;
              st   <= SQ_IDLE;
            end else begin
              idx      <= idx + CW'(1);
              cur_addr <= cur_addr + AW'(1);
              st       <= SQ_ISSUE;
            end
          end else if (poll_out) begin
            err_timeout <= 1'b1;
            done        <= 1'b1;
            st          <= SQ_IDLE;
          end else begin
            poll <= poll + PW'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st != SQ_IDLE);
  assign iss_start = (st == SQ_ISSUE);
  assign iss_addr  = cur_addr;
  assign cancel    = poll_out;
endmodule

// File: rtl/nvm_word_reader.sv
module nvm_word_reader
  import nvm_rd_pkg::*;
#(
  parameter int POLL_LIMIT = 100000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_wr_en,
  input  logic [REG_W-1:0]     host_wdata,
  output logic [REG_W-1:0]     host_rdata,
  input  logic                 seq_start,
  input  logic [ADDR_W-1:0]    seq_offset,
  input  logic [CNT_W-1:0]     seq_count,
  input  logic [CNT_W-1:0]     dev_words,
  output logic                 seq_busy,
  output logic                 seq_word_valid,
  output logic [DATA_W-1:0]    seq_word_data,
  output logic [CNT_W-1:0]     seq_word_idx,
  output logic                 seq_done,
  output logic                 seq_err_bounds,
  output logic                 seq_err_timeout,
  output logic                 be_req,
  output logic [ADDR_W-1:0]    be_addr,
  input  logic                 be_ack,
  input  logic [DATA_W-1:0]    be_rdata
);
  logic              r_busy;
  logic              r_done;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_data;
  logic              s_iss;
  logic [ADDR_W-1:0] s_addr;
  logic              s_cancel;
  logic              host_ok;
  logic              wr_start;
  logic [ADDR_W-1:0] wr_addr;
  logic              wdata_unused;

  assign wdata_unused = ^{host_wdata[REG_W-1:DATA_LSB], host_wdata[DONE_BIT]};

  assign host_ok  = host_wr_en && !seq_busy && !seq_start;
  assign wr_start = seq_busy ? s_iss  : (host_ok && host_wdata[START_BIT]);
  assign wr_addr  = seq_busy ? s_addr : host_wdata[ADDR_LSB +: ADDR_W];

  nvm_ctl_reg #(.AW(ADDR_W), .DW(DATA_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_start (wr_start),
    .wr_addr  (wr_addr),
    .cancel   (s_cancel),
    .busy     (r_busy),
    .done     (r_done),
    .addr_q   (r_addr),
    .data_q   (r_data),
    .be_req   (be_req),
    .be_addr  (be_addr),
    .be_ack   (be_ack),
    .be_rdata (be_rdata)
  );

  nvm_seq #(.AW(ADDR_W), .CW(CNT_W), .DW(DATA_W), .POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (seq_start),
    .offset      (seq_offset),
    .count       (seq_count),
    .size        (dev_words),
    .busy        (seq_busy),
    .word_valid  (seq_word_valid),
    .word_data   (seq_word_data),
    .word_idx    (seq_word_idx),
    .done        (seq_done),
    .err_bounds  (seq_err_bounds),
    .err_timeout (seq_err_timeout),
    .iss_start   (s_iss),
    .iss_addr    (s_addr),
    .cancel      (s_cancel),
    .reg_done    (r_done),
    .reg_data    (r_data)
  );

  assign host_rdata = {r_data, r_addr, r_done, r_busy};
endmodule

// File: rtl/nvm_word_reader_chk.sv
module nvm_word_reader_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] host_rdata,
  input logic        seq_word_valid,
  input logic        seq_done,
  input logic        seq_err_bounds,
  input logic        seq_err_timeout,
  input logic        be_req,
  input logic [13:0] be_addr,
  input logic        be_ack,
  input logic [15:0] be_rdata
);
  p_ack_done_r1: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_ack) |=> (host_rdata[1] && !host_rdata[0] && host_rdata[31:16] == $past(be_rdata)));

  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(host_rdata[0] && host_rdata[1]));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> (be_req || seq_err_timeout));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> $stable(be_addr));

  p_word_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    seq_word_valid |-> $past(host_rdata[1]));

  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    seq_err_bounds |-> (seq_done && !seq_word_valid));

  p_timeout_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    seq_err_timeout |-> (seq_done && !be_req && !host_rdata[0]));

  p_err_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seq_err_bounds, seq_err_timeout}));
endmodule

bind nvm_word_reader nvm_word_reader_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .host_rdata      (host_rdata),
  .seq_word_valid  (seq_word_valid),
  .seq_done        (seq_done),
  .seq_err_bounds  (seq_err_bounds),
  .seq_err_timeout (seq_err_timeout),
  .be_req          (be_req),
  .be_addr         (be_addr),
  .be_ack          (be_ack),
  .be_rdata        (be_rdata)
);

// File: tb/nvm_word_reader_test.sv
module nvm_word_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        seq_start = 1'b0;
  logic [13:0] seq_offset = '0;
  logic [14:0] seq_count = '0;
  logic [14:0] dev_words = 15'd8;
  logic        seq_busy, seq_word_valid, seq_done, seq_err_bounds, seq_err_timeout;
  logic [15:0] seq_word_data;
  logic [14:0] seq_word_idx;
  logic        be_req;
  logic [13:0] be_addr;
  logic        be_ack = 1'b0;
  logic [15:0] be_rdata = '0;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  int lat = 1;
  bit mute = 0;
  int bcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_word_reader #(.POLL_LIMIT(POLL)) uut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .seq_start(seq_start), .seq_offset(seq_offset),
    .seq_count(seq_count), .dev_words(dev_words), .seq_busy(seq_busy),
    .seq_word_valid(seq_word_valid), .seq_word_data(seq_word_data),
    .seq_word_idx(seq_word_idx), .seq_done(seq_done), .seq_err_bounds(seq_err_bounds),
    .seq_err_timeout(seq_err_timeout), .be_req(be_req), .be_addr(be_addr),
    .be_ack(be_ack), .be_rdata(be_rdata)
  );

  function automatic logic [15:0] word_of(input logic [13:0] a);
    return 16'(a * 16'd40503) ^ 16'h5A5A;
  endfunction

  // back-end model: acknowledge lat cycles after the request is seen
  always @(posedge clk) begin
    if (rst || be_ack) begin
      be_ack <= 1'b0;
      bcnt   <= 0;
    end else if (be_req && !mute) begin
      if (bcnt == lat - 1) begin
        be_ack   <= 1'b1;
        be_rdata <= word_of(be_addr);
      end else begin
        bcnt <= bcnt + 1;
      end
    end else begin
      bcnt <= 0;
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_start(input logic [13:0] a);
    host_wr_en = 1'b1;
    host_wdata = {16'h0000, a, 2'b01};
    tick;
    host_wr_en = 1'b0;
  endtask

  task automatic direct_read(input logic [13:0] a, input int l);
    int n;
    bit moved;
    lat = l;
    host_start(a);
    chk(host_rdata[1:0] == 2'b01 && host_rdata[31:16] == 16'h0, "R2 start clears", host_rdata, {16'h0, a, 2'b01});
    chk(be_req && be_addr == a, "R1 request address", {18'h0, be_addr}, {18'h0, a});
    n = 0;
    moved = 0;
    while (!host_rdata[1] && n < 100) begin
      if (!be_req || be_addr != a) moved = 1;
      tick;
      n++;
    end
    chk(n == l + 1 && !moved, "R4 completion timing", n, l + 1);
    chk(host_rdata == {word_of(a), a, 2'b10}, "R1 returned word", host_rdata, {word_of(a), a, 2'b10});
  endtask

  task automatic seq_run(input int off, input int cnt, input int size, input bit poke);
    bit bad, got, saw_req;
    int words, t;
    logic [31:0] exp_addr;
    bad = (off >= size) || (cnt == 0) || (cnt > size - off);
    dev_words = 15'(size);
    seq_offset = 14'(off);
    seq_count = 15'(cnt);
    seq_start = 1'b1;
    tick;
    seq_start = 1'b0;
    words = 0;
    got = 0;
    saw_req = 0;
    t = 0;
    while (!got && t < 3000) begin
      if (be_req) saw_req = 1;
      if (poke && t == 2) begin
        host_wr_en = 1'b1;
        host_wdata = {16'h0000, 14'h0100, 2'b01};
      end else begin
        host_wr_en = 1'b0;
      end
      if (seq_word_valid) begin
        chk(seq_word_idx == 15'(words) && seq_word_data == word_of(14'(off + words)),
            "R6 burst word", {seq_word_idx, 1'b0, seq_word_data}, {15'(words), 1'b0, word_of(14'(off + words))});
        words++;
      end
      if (seq_done) got = 1;
      else begin
        tick;
        t++;
      end
    end
    host_wr_en = 1'b0;
    chk(got && seq_err_bounds == bad && !seq_err_timeout, "R7 bounds verdict",
        {30'h0, seq_err_bounds, seq_err_timeout}, {30'h0, bad, 1'b0});
    chk(words == (bad ? 0 : cnt), "R6 word count", words, bad ? 0 : cnt);
    if (bad) chk(!saw_req, "R7 no request on reject", saw_req, 0);
    if (poke && !bad) begin
      exp_addr = 32'(off + cnt - 1);
      chk(host_rdata[15:2] == exp_addr[13:0], "R9 host write blocked", host_rdata[15:2], exp_addr[13:0]);
    end
    tick;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] snap;
    int addrs [5] = '{0, 1, 16383, 5461, 10922};
    int lats [4] = '{1, 2, 5, 20};
    repeat (3) tick;
    rst = 1'b0;
    chk(host_rdata == 32'h0 && !be_req && !seq_busy, "R5 reset state", host_rdata, 32'h0);

    foreach (addrs[i]) foreach (lats[j]) direct_read(14'(addrs[i]), lats[j]);

    // R3: start while busy is ignored
    lat = 10;
    host_start(14'h0123);
    tick;
    host_start(14'h0456);
    n = 0;
    while (!host_rdata[1] && n < 100) begin tick; n++; end
    chk(host_rdata == {word_of(14'h0123), 14'h0123, 2'b10}, "R3 busy start ignored",
        host_rdata, {word_of(14'h0123), 14'h0123, 2'b10});
    snap = host_rdata;
    host_wr_en = 1'b1;
    host_wdata = {16'hFFFF, 14'h0777, 2'b10};
    tick;
    host_wr_en = 1'b0;
    chk(host_rdata == snap && !be_req, "R3 write without start", host_rdata, snap);
    repeat (5) tick;
    chk(host_rdata == snap, "R2 done holds", host_rdata, snap);

    // burst sweep over two device sizes
    for (int sz = 1; sz <= 8; sz += 7)
      for (int off = 0; off < 10; off++)
        for (int cnt = 0; cnt < 10; cnt++) begin
          lat = 1 + ((off + cnt) % 4);
          seq_run(off, cnt, sz, 1'b0);
        end

    // R9: host write during a burst
    lat = 5;
    seq_run(2, 4, 8, 1'b1);

    // R8: silent back-end
    mute = 1;
    dev_words = 15'd8;
    seq_offset = 14'd3;
    seq_count = 15'd1;
    seq_start = 1'b1;
    tick;
    seq_start = 1'b0;
    n = 1;
    while (!seq_done && n < 1000) begin tick; n++; end
    chk(seq_err_timeout && !seq_err_bounds && n == POLL + 2, "R8 timeout cycle", n, POLL + 2);
    chk(!be_req && !host_rdata[0], "R8 read cancelled", {30'h0, be_req, host_rdata[0]}, 32'h0);
    mute = 0;
    tick;
    direct_read(14'h0042, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule